// File: doc/BRIEF.md
# Multiplexed LCD Display RAM Writer

This block turns a stream of display data bytes into writes to a bit-addressed display memory of 60 columns by 8 rows. The geometry of each write follows the selected multiplex mode: one active row (static), two, four, six or eight. A column pointer, set by a load command and advanced by every byte, decides where each byte lands. The eight bits of a byte are laid down most significant first, down the active rows of the current column and then on into the next column, so the pointer moves by 8, 4, 2 or 1 columns per byte. In six-row mode it also keeps a partial row position from one byte to the next.

In the modes with one, two and four active rows, the rows split into banks. The bank that receives writes and the bank that the display scanner reads are chosen on their own, so a new image can be built in hidden rows while another is shown. A combinational read port returns one column at a time, rotated so that bit 0 is the first row of the displayed bank.

Top module: `lcdram_writer`

## Requirements
- R1: After reset every memory bit is 0, the mode register holds static (code 0) and the pointer is at column 0, row 0.
- R2: `mux_mode` codes are 0 = one row, 1 = two rows, 2 = four rows, 3 = six rows, 4 = eight rows, and 5..7 act as eight rows. A write stores `wr_byte[7]` first at the pointer's column and row, then each following bit one row lower, moving to row 0 of the next column after the last active row.
- R3: After a write the pointer sits just past the eighth bit: 8 columns on in static mode, 4 in two-row mode, 2 in four-row mode, 1 in eight-row mode. In six-row mode the column and a row remainder of 0, 2 or 4 advance together.
- R4: Bits that would fall past the last active row of column 59 are discarded, and the pointer returns to column 0, row 0.
- R5: `ptr_load` with `ptr_col` below 60 moves the pointer to that column, row 0, before a write in the same cycle. A `ptr_col` of 60 or more leaves the pointer unchanged.
- R6: A cycle in which `mux_mode` differs from the registered mode puts the pointer at column 0, row 0. A load or write in that cycle then acts from there in the new mode.
- R7: In modes 0, 1 and 2 a write lands at row offset `in_bank` with its low bits cleared to a multiple of the active row count: any row in static mode, 0/2/4/6 in two-row mode, 0/4 in four-row mode. In six- and eight-row modes `in_bank` is ignored and the offset is 0.
- R8: `rd_data[k]` equals memory bit (column `rd_col`, row (B + k) mod 8). B is derived from `out_bank` by the rule of R7 under the current `mux_mode`.
- R9: With `rd_col` of 60 or more, `rd_data` is all zeros.
- R10: A write changes only the memory bits it addresses, and a cycle without a write changes no memory bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_mode | input | 3 | Multiplex mode code |
| in_bank | input | 3 | Row bank that receives writes |
| out_bank | input | 3 | Row bank presented on the read port |
| ptr_load | input | 1 | Load the pointer from `ptr_col` |
| ptr_col | input | 6 | Column for a pointer load |
| wr_en | input | 1 | Store `wr_byte` this cycle |
| wr_byte | input | 8 | Display data byte |
| rd_col | input | 6 | Column requested by the scanner |
| rd_data | output | 8 | Rows of that column, from the output bank |

## Verification
Assertions watch the pointer on every cycle. It must stay inside the active geometry and return to the origin after a mode change or a write in the last column. It must take a loaded column, step by eight columns per static byte, and leave the memory untouched when no write happens. Bit placement across columns, the six-row carry, the bits dropped at the boundary, the bank offsets and the rotated read data can only be shown by the bench's scenarios. Those scenarios compare every read against a linear bit-index model of the memory and sweep all columns after each pattern.

// File: rtl/lcdram_pkg.sv
package lcdram_pkg;

    localparam int LCDRAM_ROWS = 8;

    localparam logic [2:0] MODE_STATIC = 3'd0;
    localparam logic [2:0] MODE_MUX2   = 3'd1;
    localparam logic [2:0] MODE_MUX4   = 3'd2;
    localparam logic [2:0] MODE_MUX6   = 3'd3;

    // active row count for a mode code; codes 4..7 use all eight rows
    function automatic logic [3:0] rows_of(input logic [2:0] mode);
        case (mode)
            MODE_STATIC: rows_of = 4'd1;
            MODE_MUX2:   rows_of = 4'd2;
            MODE_MUX4:   rows_of = 4'd4;
            MODE_MUX6:   rows_of = 4'd6;
            default:     rows_of = 4'd8;
        endcase
    endfunction

    // first row of a bank; banking exists only with 1, 2 or 4 rows
    function automatic logic [2:0] bank_base(input logic [2:0] mode,
                                             input logic [2:0] bank);
        case (mode)
            MODE_STATIC: bank_base = bank;
            MODE_MUX2:   bank_base = {bank[2:1], 1'b0};
            MODE_MUX4:   bank_base = {bank[2], 2'b00};
            default:     bank_base = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/lcdram_place.sv
module lcdram_place #(
    parameter int COLS = 60,
    parameter int DW   = 8,
    localparam int CW  = $clog2(COLS)
) (
    input  logic [CW-1:0]          start_col,
    input  logic [2:0]             start_row,
    input  logic [3:0]             rows,
    input  logic [2:0]             base,
    input  logic [DW-1:0]          data,
    output logic [DW-1:0]          bit_ok,
    output logic [DW-1:0][CW-1:0]  bit_col,
    output logic [DW-1:0][2:0]     bit_row,
    output logic [DW-1:0]          bit_val,
    output logic [CW-1:0]          next_col,
    output logic [2:0]             next_row
);
    logic [CW-1:0] c;
    logic [3:0]    r;
    logic          ovf;

    always_comb begin
        c   = start_col;
        r   = {1'b0, start_row};
        ovf = 1'b0;
        for (int i = 0; i < DW; i++) begin
            bit_col[i] = c;
            bit_row[i] = base + r[2:0];
            bit_val[i] = data[DW-1-i];
            bit_ok[i]  = !ovf;
            r = r + 4'd1;
            if (r == rows) begin
                r = 4'd0;
                if (c == CW'(COLS-1)) ovf = 1'b1;
                else                  c   = c + CW'(1);
            end
        end
        next_col = ovf ? '0 : c;
        next_row = ovf ? '0 : r[2:0];
    end

endmodule

// File: rtl/lcdram_store.sv
module lcdram_store #(
    parameter int COLS = 60,
    parameter int DW   = 8,
    localparam int CW  = $clog2(COLS),
    localparam int NR  = lcdram_pkg::LCDRAM_ROWS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DW-1:0]          bit_we,
    input  logic [DW-1:0][CW-1:0]  bit_col,
    input  logic [DW-1:0][2:0]     bit_row,
    input  logic [DW-1:0]          bit_val,
    input  logic [CW-1:0]          rd_col,
    input  logic [2:0]             out_base,
    output logic [NR-1:0]          rd_data
);
    logic [COLS-1:0][NR-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < DW; i++) begin
            if (bit_we[i]) mem_d[bit_col[i]][bit_row[i]] = bit_val[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_col < CW'(COLS)) begin
            for (int k = 0; k < NR; k++) begin
                rd_data[k] = mem_q[rd_col][3'(out_base + 3'(k))];
            end
        end
    end

    AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|bit_we) |=> $stable(mem_q)); // R10

endmodule

// File: rtl/lcdram_writer.sv
module lcdram_writer #(
    parameter int COLS = 60,
    parameter int DW   = 8,
    localparam int CW  = $clog2(COLS),
    localparam int NR  = lcdram_pkg::LCDRAM_ROWS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mux_mode,
    input  logic [2:0]    in_bank,
    input  logic [2:0]    out_bank,
    input  logic          ptr_load,
    input  logic [CW-1:0] ptr_col,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_byte,
    input  logic [CW-1:0] rd_col,
    output logic [NR-1:0] rd_data
);
    import lcdram_pkg::*;

    typedef struct packed {
        logic [2:0]    mode;
        logic [CW-1:0] col;
        logic [2:0]    row;
    } wstate_t;

    wstate_t st_d, st_q;

    logic [CW-1:0]         start_col, next_col;
    logic [2:0]            start_row, next_row;
    logic [DW-1:0]         bit_ok, bit_val;
    logic [DW-1:0][CW-1:0] bit_col;
    logic [DW-1:0][2:0]    bit_row;
    logic [2:0]            in_base, out_base;

    always_comb begin
        in_base  = bank_base(mux_mode, in_bank);
        out_base = bank_base(mux_mode, out_bank);
        if (mux_mode != st_q.mode) begin
            start_col = '0;
            start_row = '0;
        end else begin
            start_col = st_q.col;
            start_row = st_q.row;
        end
        if (ptr_load && ptr_col < CW'(COLS)) begin
            start_col = ptr_col;
            start_row = '0;
        end
        st_d.mode = mux_mode;
        st_d.col  = wr_en ? next_col : start_col;
        st_d.row  = wr_en ? next_row : start_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lcdram_place #(.COLS(COLS), .DW(DW)) i_place (
        .start_col (start_col),
        .start_row (start_row),
        .rows      (rows_of(mux_mode)),
        .base      (in_base),
        .data      (wr_byte),
        .bit_ok    (bit_ok),
        .bit_col   (bit_col),
        .bit_row   (bit_row),
        .bit_val   (bit_val),
        .next_col  (next_col),
        .next_row  (next_row)
    );

    lcdram_store #(.COLS(COLS), .DW(DW)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_we   (bit_ok & {DW{wr_en}}),
        .bit_col  (bit_col),
        .bit_row  (bit_row),
        .bit_val  (bit_val),
        .rd_col   (rd_col),
        .out_base (out_base),
        .rd_data  (rd_data)
    );

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.col < CW'(COLS) && {1'b0, st_q.row} < rows_of(st_q.mode)); // R3

    AST_MODE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode != st_q.mode) && !ptr_load && !wr_en
        |=> st_q.col == '0 && st_q.row == '0); // R6

    AST_LOAD_COL: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load && ptr_col < CW'(COLS) && !wr_en
        |=> st_q.col == $past(ptr_col) && st_q.row == '0); // R5

    AST_STATIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !ptr_load && mux_mode == MODE_STATIC && st_q.mode == MODE_STATIC
        && st_q.col < CW'(COLS-8)
        |=> st_q.col == $past(st_q.col) + CW'(8)); // R3

    AST_WRAP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !ptr_load && mux_mode == st_q.mode && st_q.col == CW'(COLS-1)
        |=> st_q.col == '0 && st_q.row == '0); // R4

endmodule

// File: tb/test_lcdram_writer.sv
module test_lcdram_writer;
    localparam int COLS = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mux_mode = 3'd0, in_bank = 3'd0, out_bank = 3'd0;
    logic       ptr_load = 1'b0, wr_en = 1'b0;
    logic [5:0] ptr_col = 6'd0, rd_col = 6'd0;
    logic [7:0] wr_byte = 8'd0;
    logic [7:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model: linear bit index within the active rows
    bit ref_mem [COLS][8];
    int m_mode = 0, m_col = 0, m_row = 0;

    always #2 clk = ~clk;

    lcdram_writer i_lcdram_writer (
        .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .in_bank(in_bank),
        .out_bank(out_bank), .ptr_load(ptr_load), .ptr_col(ptr_col),
        .wr_en(wr_en), .wr_byte(wr_byte), .rd_col(rd_col), .rd_data(rd_data)
    );

    function automatic int nrows(int m);
        case (m)
            0: return 1; 1: return 2; 2: return 4; 3: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int offs(int m, int bank);
        int r = nrows(m);
        if (r <= 4) return bank - (bank % r);
        return 0;
    endfunction

    function automatic logic [7:0] exp_read(int col);
        logic [7:0] v = '0;
        int b = offs(mux_mode, out_bank);
        if (col >= COLS) return v;
        for (int k = 0; k < 8; k++) v[k] = ref_mem[col][(b + k) % 8];
        return v;
    endfunction

    task automatic model_edge();
        int r = nrows(mux_mode);
        int total = COLS * r;
        int p;
        if (mux_mode != m_mode) begin m_col = 0; m_row = 0; m_mode = mux_mode; end
        if (ptr_load && ptr_col < COLS) begin m_col = ptr_col; m_row = 0; end
        if (wr_en) begin
            p = m_col * r + m_row;
            for (int i = 0; i < 8; i++)
                if (p + i < total)
                    ref_mem[(p + i) / r][offs(mux_mode, in_bank) + (p + i) % r] = wr_byte[7 - i];
            p = p + 8;
            if (p >= total) p = 0;
            m_col = p / r;
            m_row = p % r;
        end
    endtask

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s col %0d: got %02h expected %02h", tag, rd_col, got, exp);
        end
    endtask

    // one clock: inputs already driven away from the edge
    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag, rd_data, exp_read(rd_col));
        @(negedge clk);
        ptr_load = 0; wr_en = 0;
    endtask

    task automatic wr(logic [7:0] b, string tag);
        wr_en = 1; wr_byte = b;
        tick(tag);
    endtask

    task automatic load(int c, string tag);
        ptr_load = 1; ptr_col = 6'(c);
        tick(tag);
    endtask

    task automatic sweep(string tag);
        for (int c = 0; c < 64; c++) begin
            rd_col = 6'(c);
            #1;
            check(tag, rd_data, exp_read(c));
        end
        rd_col = 0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < COLS; c++) for (int r = 0; r < 8; r++) ref_mem[c][r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        sweep("R1");

        // static mode: one row, pointer steps 8
        wr(8'hA5, "R2"); wr(8'h3C, "R3"); wr(8'hFF, "R3");
        sweep("R2");
        // boundary: columns 57..59 then discard and wrap
        load(57, "R5"); wr(8'hE7, "R4"); wr(8'h81, "R4");
        sweep("R4");
        // out-of-range load ignored, write continues at pointer
        load(61, "R5"); wr(8'h55, "R5");
        sweep("R5");
        // static banks: write row 5, display row 5
        in_bank = 5; load(10, "R7"); wr(8'hC3, "R7");
        out_bank = 5; sweep("R8");
        out_bank = 0; in_bank = 0;

        // two-row mode: mode change resets pointer; bank 3 -> rows 2,3
        mux_mode = 1; in_bank = 3; wr(8'h96, "R6"); wr(8'h0F, "R2");
        out_bank = 2; sweep("R7");
        load(59, "R4"); wr(8'hFF, "R4"); wr(8'h12, "R4");
        sweep("R4");

        // four-row mode, write bank 4, view bank 0 then 4
        mux_mode = 2; in_bank = 4; out_bank = 0;
        for (int i = 0; i < 31; i++) wr(8'(i * 37 + 11), "R3");
        sweep("R8");
        out_bank = 7; sweep("R8");

        // six-row mode: row carry into next column, full fill plus wrap
        mux_mode = 3; in_bank = 6; out_bank = 6;
        for (int i = 0; i < 46; i++) wr(8'(i * 53 + 7), "R3");
        sweep("R7");
        load(59, "R4"); wr(8'h6B, "R4");
        load(58, "R5"); wr(8'hD2, "R3"); wr(8'h4E, "R3"); wr(8'hB9, "R4");
        sweep("R3");

        // eight-row mode and an alias code
        mux_mode = 4; in_bank = 3; out_bank = 5;
        load(20, "R5"); wr(8'h5A, "R2"); wr(8'hC1, "R2");
        load(59, "R4"); wr(8'h77, "R4"); wr(8'h18, "R4");
        sweep("R2");
        mux_mode = 6; wr(8'h99, "R6"); ptr_load = 1; ptr_col = 6'd30; wr(8'h24, "R5");
        sweep("R2");

        // load and write in the same cycle as a mode change
        mux_mode = 0; ptr_load = 1; ptr_col = 6'd40; wr(8'hF0, "R6");
        sweep("R6");

        // idle cycles: memory unchanged
        repeat (4) tick("R10");
        sweep("R10");

        // read of nonexistent columns
        rd_col = 62; #1; check("R9", rd_data, 8'h00);
        rd_col = 60; #1; check("R9", rd_data, 8'h00);
        rd_col = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule